// File: doc/BRIEF.md
# Masked packed integer-to-float converter

This block takes a vector of up to sixteen signed 32-bit integers and turns each one into an IEEE-754 single-precision value. Each 32-bit lane keeps its bit position, so lane j occupies bits 32j+31 down to 32j in both the source and the result. A length select sets the number of active lanes to 4, 8 or 16. A per-lane mask then decides which of those lanes receive the converted value. A masked-off lane either keeps the matching lane of a previous-destination vector or is written with zero. Lanes above the active length are zeroed, unless the keep-upper input is set, in which case they pass the previous destination through unchanged.

When the source is marked as coming from memory and broadcast is requested, every lane converts source element 0. The rounding mode normally comes from a global two-bit control. A per-operation two-bit field replaces it only for a 16-lane operation with a register source and the override bit set. The only floating-point condition the block detects is inexactness. It is gathered from the lanes that are written with a converted value, and it collects into a sticky flag that only an explicit clear input resets.

Operands enter through a valid/ready input handshake, and the result leaves through a valid/ready output handshake. A single output register sits between the two:
- The block takes an operation on a rising clock edge when both `in_valid` and `in_ready` are high.
- `in_ready` is high whenever the output register is empty or is being drained in that same cycle.
- The result and `out_valid` appear in the cycle after the operation is taken.
- While `out_valid` is high and `out_ready` is low, the result is held stable and no new operation is taken.

Top module: `vec_i2f_cvt`

## Requirements
- R1: Each lane converts its two's-complement integer exactly when the magnitude is below 2^24. Zero gives 0x00000000 (+0.0), -1 gives 0xBF800000, and -2^31 gives 0xCF000000. Lane j of `res_vec` comes from lane j of `src_vec`.
- R2: Larger magnitudes are rounded by the selected mode: 00 to nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. A carry out of the mantissa raises the exponent; for example, 0x7FFFFFFF rounded to nearest gives 0x4F000000.
- R3: `vlen_sel` 00 selects 4 active lanes, 01 selects 8, and 10 or 11 selects 16. With `keep_upper` low, every result lane at or above the active count is 0.
- R4: With `keep_upper` high, every result lane at or above the active count equals the same lane of `old_dst`.
- R5: An active lane receives the converted value when `mask_en` is 0, or when its bit in `lane_mask` (bit j for lane j) is 1.
- R6: An active lane whose mask bit is 0 while `mask_en` is 1 takes the matching `old_dst` lane when `zero_mode` is 0, and 0 when `zero_mode` is 1.
- R7: With `bcast` and `src_is_mem` both 1, every lane converts bits 31:0 of `src_vec`. With `src_is_mem` 0, `bcast` has no effect.
- R8: `op_rm` selects the rounding mode only when 16 lanes are active, `src_is_mem` is 0 and `rm_override` is 1. In every other case `glob_rm` is used.
- R9: `inexact_flag` is set by a taken operation in which an active lane that receives a converted value was rounded. A masked-off or inactive lane that would round does not set it.
- R10: `inexact_flag` stays set until `clr_inexact` is high at a clock edge. If a clear and an operation are taken at the same edge, the flag reflects only the new operation.
- R11: The result is registered. It appears with `out_valid` one cycle after acceptance, and it stays stable while `out_valid` is high and `out_ready` is low. `in_ready` is low only while a held result is waiting.
- R12: After reset, `out_valid`, `inexact_flag` and `res_vec` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| src_vec | input | 512 | Source integers, 32 bits per lane |
| old_dst | input | 512 | Previous destination vector, used by merge and keep-upper |
| lane_mask | input | 16 | Per-lane write mask, bit j for lane j |
| mask_en | input | 1 | 1 applies lane_mask, 0 writes all active lanes |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges them from old_dst |
| vlen_sel | input | 2 | Active lane count: 00=4, 01=8, 1x=16 |
| keep_upper | input | 1 | 1 passes old_dst through in the lanes above the active count |
| src_is_mem | input | 1 | Source marked as memory operand |
| bcast | input | 1 | Broadcast element 0 (only with src_is_mem) |
| glob_rm | input | 2 | Global rounding mode |
| op_rm | input | 2 | Per-operation rounding mode |
| rm_override | input | 1 | Request use of op_rm |
| clr_inexact | input | 1 | Clears the sticky inexact flag |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| res_vec | output | 512 | Converted result vector |
| inexact_flag | output | 1 | Sticky inexact indication |

## Verification
The hardest case to reach from the ports is a lane that would round but is not written: it is masked off or above the active length, while its neighbours convert exactly. The sticky flag must stay clear in that case, even though the converter for that lane does produce an inexact indication. The bench builds it by placing 0x7FFFFFFF only in a masked-off lane 0, and separately in lane 5 of a 4-lane operation. Each time it clears the flag first and surrounds the value with exact lanes. The rounding-override gate is probed by repeating one operation while changing only the lane count, and then only the memory marking, and checking that the result switches back to the global rounding mode.

// File: rtl/vi2f_pkg.sv
package vi2f_pkg;
  localparam int ELEM_W = 32;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  // Active lane count for a length code: 00=4, 01=8, otherwise 16.
  function automatic int unsigned active_lanes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4;
      2'b01:   return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/vi2f_lzc.sv
module vi2f_lzc #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt
);
  // Scan upward so the highest set bit wins.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/vi2f_lane.sv
module vi2f_lane
  import vi2f_pkg::*;
(
  input  logic [ELEM_W-1:0] ival,
  input  rmode_e            rm,
  output logic [ELEM_W-1:0] fval,
  output logic              inexact
);
  localparam int LZW = $clog2(ELEM_W + 1);

  logic              sgn;
  logic [ELEM_W-1:0] mag;
  logic [LZW-1:0]    lz;
  logic [ELEM_W-1:0] norm;
  logic [7:0]        expo;
  logic [22:0]       frac;
  logic              guard, stk, lsb, bump;
  logic [30:0]       body;

  assign sgn = ival[ELEM_W-1];
  assign mag = sgn ? (~ival + 32'd1) : ival;

  vi2f_lzc #(.W(ELEM_W)) u_lzc (.din(mag), .cnt(lz));

  // Leading one moved to bit 31; it becomes the hidden bit.
  assign norm  = mag << lz[LZW-2:0];
  assign expo  = 8'd158 - {2'b00, lz};
  assign frac  = norm[30:8];
  assign lsb   = norm[8];
  assign guard = norm[7];
  assign stk   = |norm[6:0];

  always_comb begin
    case (rm)
      RM_NEAR: bump = guard & (stk | lsb);
      RM_DOWN: bump = (guard | stk) & sgn;
      RM_UP:   bump = (guard | stk) & ~sgn;
      default: bump = 1'b0;
    endcase
  end

  // A mantissa carry ripples into the exponent field.
  assign body    = {expo, frac} + 31'(bump);
  assign fval    = (mag == '0) ? '0 : {sgn, body};
  assign inexact = (mag != '0) & (guard | stk);
endmodule

// File: rtl/vi2f_lane_sel.sv
module vi2f_lane_sel
  import vi2f_pkg::*;
(
  input  logic [ELEM_W-1:0] conv,
  input  logic [ELEM_W-1:0] prev,
  input  logic              active,
  input  logic              wr_en,
  input  logic              zero_mode,
  input  logic              keep_upper,
  output logic [ELEM_W-1:0] lane_out
);
  always_comb begin
    if (!active)     lane_out = keep_upper ? prev : '0;
    else if (wr_en)  lane_out = conv;
    else             lane_out = zero_mode ? '0 : prev;
  end
endmodule

// File: rtl/vec_i2f_cvt.sv
module vec_i2f_cvt
  import vi2f_pkg::*;
#(
  parameter int LANES = 16,
  localparam int DW = LANES * ELEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    src_vec,
  input  logic [DW-1:0]    old_dst,
  input  logic [LANES-1:0] lane_mask,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic [1:0]       vlen_sel,
  input  logic             keep_upper,
  input  logic             src_is_mem,
  input  logic             bcast,
  input  logic [1:0]       glob_rm,
  input  logic [1:0]       op_rm,
  input  logic             rm_override,
  input  logic             clr_inexact,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    res_vec,
  output logic             inexact_flag
);
  logic              accept;
  logic              use_bcast;
  logic              full_len;
  rmode_e            rm_sel;
  int unsigned       n_act;
  logic [DW-1:0]     nxt_vec;
  logic [LANES-1:0]  lane_inx;

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign use_bcast = bcast && src_is_mem;
  assign n_act     = active_lanes(vlen_sel);
  assign full_len  = (n_act == 16);
  assign rm_sel    = (full_len && !src_is_mem && rm_override) ? rmode_e'(op_rm)
                                                               : rmode_e'(glob_rm);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [ELEM_W-1:0] din;
    logic [ELEM_W-1:0] conv;
    logic              inx;
    logic              act;
    logic              wr;

    assign din = use_bcast ? src_vec[ELEM_W-1:0] : src_vec[j*ELEM_W +: ELEM_W];
    assign act = (j < n_act);
    assign wr  = !mask_en || lane_mask[j];

    vi2f_lane u_cvt (.ival(din), .rm(rm_sel), .fval(conv), .inexact(inx));

    vi2f_lane_sel u_sel (
      .conv      (conv),
      .prev      (old_dst[j*ELEM_W +: ELEM_W]),
      .active    (act),
      .wr_en     (wr),
      .zero_mode (zero_mode),
      .keep_upper(keep_upper),
      .lane_out  (nxt_vec[j*ELEM_W +: ELEM_W])
    );

    assign lane_inx[j] = act && wr && inx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      res_vec      <= '0;
      inexact_flag <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        res_vec   <= nxt_vec;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      inexact_flag <= (inexact_flag && !clr_inexact) || (accept && |lane_inx);
    end
  end
endmodule

// File: rtl/vec_i2f_cvt_chk.sv
module vec_i2f_cvt_chk #(
  parameter int LANES = 16,
  localparam int DW = LANES * 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [DW-1:0]    old_dst,
  input logic [LANES-1:0] lane_mask,
  input logic             mask_en,
  input logic             zero_mode,
  input logic [1:0]       vlen_sel,
  input logic             keep_upper,
  input logic             clr_inexact,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    res_vec,
  input logic             inexact_flag
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_vec));

  assert_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && vlen_sel == 2'b00 && !keep_upper |=> res_vec[DW-1:128] == '0);

  assert_upper_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && vlen_sel == 2'b00 && keep_upper |=> res_vec[DW-1:128] == $past(old_dst[DW-1:128]));

  assert_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mask_en && !lane_mask[0] && !zero_mode |=> res_vec[31:0] == $past(old_dst[31:0]));

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mask_en && !lane_mask[0] && zero_mode |=> res_vec[31:0] == 32'd0);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inexact_flag && !clr_inexact |=> inexact_flag);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_inexact && !acc |=> !inexact_flag);
endmodule

bind vec_i2f_cvt vec_i2f_cvt_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .old_dst     (old_dst),
  .lane_mask   (lane_mask),
  .mask_en     (mask_en),
  .zero_mode   (zero_mode),
  .vlen_sel    (vlen_sel),
  .keep_upper  (keep_upper),
  .clr_inexact (clr_inexact),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .res_vec     (res_vec),
  .inexact_flag(inexact_flag)
);

// File: tb/tb_vec_i2f_cvt.sv
module tb_vec_i2f_cvt;
  localparam int LANES = 16;
  localparam int DW = LANES * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [DW-1:0] src_vec = '0, old_dst = '0, res_vec;
  logic [LANES-1:0] lane_mask = '0;
  logic mask_en = 0, zero_mode = 0, keep_upper = 0, src_is_mem = 0, bcast = 0;
  logic [1:0] vlen_sel = 2'b00, glob_rm = 2'b00, op_rm = 2'b00;
  logic rm_override = 0, clr_inexact = 0, out_valid, out_ready = 1'b1, inexact_flag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vec_i2f_cvt #(.LANES(LANES)) dut (.*);

  // value[66:35] rounding[34:33] expected[32:1] inexact[0]
  localparam logic [66:0] TBL [15] = '{
    {32'h00000000, 2'b00, 32'h00000000, 1'b0},
    {32'h00000001, 2'b00, 32'h3F800000, 1'b0},
    {32'hFFFFFFFF, 2'b00, 32'hBF800000, 1'b0},
    {32'h00000064, 2'b11, 32'h42C80000, 1'b0},
    {32'h80000000, 2'b00, 32'hCF000000, 1'b0},
    {32'h7FFFFFFF, 2'b00, 32'h4F000000, 1'b1},
    {32'h7FFFFFFF, 2'b11, 32'h4EFFFFFF, 1'b1},
    {32'h7FFFFFFF, 2'b01, 32'h4EFFFFFF, 1'b1},
    {32'h7FFFFFFF, 2'b10, 32'h4F000000, 1'b1},
    {32'h01000001, 2'b00, 32'h4B800000, 1'b1},
    {32'h01000001, 2'b10, 32'h4B800001, 1'b1},
    {32'h01000003, 2'b00, 32'h4B800002, 1'b1},
    {32'hFEFFFFFF, 2'b01, 32'hCB800001, 1'b1},
    {32'hFEFFFFFF, 2'b10, 32'hCB800000, 1'b1},
    {32'h01000000, 2'b11, 32'h4B800000, 1'b0}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire();
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    clr_inexact = 1'b1;
    @(negedge clk);
    clr_inexact = 1'b0;
  endtask

  task automatic defaults();
    mask_en = 0; zero_mode = 0; keep_upper = 0; src_is_mem = 0; bcast = 0;
    vlen_sel = 2'b00; glob_rm = 2'b00; op_rm = 2'b00; rm_override = 0;
    lane_mask = '0; out_ready = 1'b1;
    for (int j = 0; j < LANES; j++) old_dst[j*32 +: 32] = 32'hAAAA0000 + j;
  endtask

  function automatic logic [DW-1:0] fill(input logic [31:0] v, input int n);
    logic [DW-1:0] r = '0;
    for (int j = 0; j < n; j++) r[j*32 +: 32] = v;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp;
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 out_valid", DW'(out_valid), '0);
    chk("R12 inexact", DW'(inexact_flag), '0);
    chk("R12 res_vec", res_vec, '0);
    chk("R12 in_ready", DW'(in_ready), DW'(1));

    // R1 R2 R5 vector table, mask bits ignored when mask_en=0
    for (int i = 0; i < 15; i++) begin
      clear_flag();
      defaults();
      src_vec = fill(TBL[i][66:35], 4);
      glob_rm = TBL[i][34:33];
      fire();
      chk($sformatf("R1/R2 row %0d value", i), res_vec, fill(TBL[i][32:1], 4));
      chk($sformatf("R2 row %0d inexact", i), DW'(inexact_flag), DW'(TBL[i][0]));
    end

    // R6 merge and zero of masked-off lanes
    defaults();
    src_vec = fill(32'd2, 16);
    mask_en = 1; lane_mask = 16'h0005;
    fire();
    exp = '0;
    exp[31:0] = 32'h40000000; exp[63:32] = old_dst[63:32];
    exp[95:64] = 32'h40000000; exp[127:96] = old_dst[127:96];
    chk("R6 merge", res_vec, exp);
    zero_mode = 1;
    fire();
    exp[63:32] = '0; exp[127:96] = '0;
    chk("R6 zero", res_vec, exp);

    // R3 lane counts
    defaults();
    src_vec = fill(32'd1, 16);
    vlen_sel = 2'b01;
    fire();
    chk("R3 eight lanes", res_vec, fill(32'h3F800000, 8));
    vlen_sel = 2'b10;
    fire();
    chk("R3 sixteen lanes", res_vec, fill(32'h3F800000, 16));
    vlen_sel = 2'b11;
    fire();
    chk("R3 code 11", res_vec, fill(32'h3F800000, 16));

    // R4 keep upper lanes
    vlen_sel = 2'b00; keep_upper = 1;
    fire();
    exp = old_dst;
    exp[127:0] = fill(32'h3F800000, 4);
    chk("R4 keep upper", res_vec, exp);

    // R7 broadcast
    defaults();
    for (int j = 0; j < LANES; j++) src_vec[j*32 +: 32] = j + 1;
    vlen_sel = 2'b01; bcast = 1; src_is_mem = 1;
    fire();
    chk("R7 broadcast mem", res_vec, fill(32'h3F800000, 8));
    src_is_mem = 0;
    fire();
    chk("R7 bcast ignored lane1", DW'(res_vec[63:32]), DW'(32'h40000000));
    chk("R7 bcast ignored lane3", DW'(res_vec[127:96]), DW'(32'h40800000));

    // R8 rounding source
    defaults();
    src_vec = fill(32'h7FFFFFFF, 16);
    glob_rm = 2'b00; op_rm = 2'b11; rm_override = 1; vlen_sel = 2'b10;
    fire();
    chk("R8 override used", res_vec, fill(32'h4EFFFFFF, 16));
    vlen_sel = 2'b01;
    fire();
    chk("R8 override needs 16 lanes", res_vec, fill(32'h4F000000, 8));
    vlen_sel = 2'b10; src_is_mem = 1;
    fire();
    chk("R8 override needs reg source", res_vec, fill(32'h4F000000, 16));

    // R9 masked-off and inactive lanes do not set the flag
    clear_flag();
    defaults();
    src_vec = fill(32'd1, 16);
    src_vec[31:0] = 32'h7FFFFFFF;
    mask_en = 1; lane_mask = 16'hFFFE;
    fire();
    chk("R9 masked lane no inexact", DW'(inexact_flag), '0);
    defaults();
    src_vec = fill(32'd1, 16);
    src_vec[191:160] = 32'h7FFFFFFF;
    fire();
    chk("R9 inactive lane no inexact", DW'(inexact_flag), '0);
    chk("R3 inactive lane zeroed", res_vec, fill(32'h3F800000, 4));

    // R10 sticky and clear
    src_vec = fill(32'h7FFFFFFF, 4);
    fire();
    chk("R9 set", DW'(inexact_flag), DW'(1));
    src_vec = fill(32'd1, 4);
    fire();
    chk("R10 sticky", DW'(inexact_flag), DW'(1));
    clear_flag();
    chk("R10 cleared", DW'(inexact_flag), '0);
    src_vec = fill(32'h7FFFFFFF, 4);
    fire();
    @(negedge clk);
    clr_inexact = 1; in_valid = 1; src_vec = fill(32'd1, 4);
    @(negedge clk);
    clr_inexact = 0; in_valid = 0;
    chk("R10 clear with exact op", DW'(inexact_flag), '0);

    // R11 back-pressure
    defaults();
    src_vec = fill(32'd1, 4);
    out_ready = 0;
    fire();
    chk("R11 valid", DW'(out_valid), DW'(1));
    src_vec = fill(32'd2, 4);
    in_valid = 1;
    @(negedge clk);
    chk("R11 not ready", DW'(in_ready), '0);
    chk("R11 held", res_vec, fill(32'h3F800000, 4));
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R11 next taken", res_vec, fill(32'h40000000, 4));
    @(negedge clk);
    chk("R11 drained", DW'(out_valid), '0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule